// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits in front of an embedded flash controller and decides, one request at a time, whether a read, program or erase may go ahead. A request names its kind (read or write, where write stands for both program and erase), the region it targets and a page number inside main flash. The decision uses four things. The first is two range-decoded write-protect zones. The second is a boot-time secure area at the bottom of main flash, which locks once per reset. The third is a read-protection level that blocks all writes while a debugger is attached or while code runs from RAM or system memory. The fourth is the target region itself: the one-time-programmable area and the system region can never be written.

Zone bounds are staged on input pins and take effect only when an option-reload strobe arrives. The secure area's size is a page count held in the block. Its enable bit can be set but never cleared until the next reset. The decision is registered. An allowed request produces a one-cycle grant pulse on the following cycle. A refused request produces no grant and sets one of two sticky error flags. Software clears each flag with a write-one-to-clear strobe.

Top module: `flash_guard`

## Requirements
- R1: A zone whose loaded start page equals its loaded end page write-protects that single page and no neighbour.
- R2: A zone whose loaded start page is above its loaded end page protects no page. After reset both zones hold start 255 and end 0, so they protect nothing.
- R3: A zone whose loaded start page is below its loaded end page write-protects every page from start to end inclusive. Zones never affect reads.
- R4: Region code 0 is main flash, 1 is the one-time-programmable area, and 2 and 3 are system regions that can never be written. A write to any region other than 0 is refused and sets the write-protect error. A read of such a region is granted.
- R5: While the read-protection level is nonzero, every write is refused with the write-protect error when the debug-attached flag or the boot-from-RAM/system flag is high, even if no zone covers the page. At level 0 these flags have no effect.
- R6: Staged zone bounds are ignored until the option-reload strobe is high on a clock edge. A request in that same cycle is still judged against the old bounds.
- R7: The secure area covers main-flash pages 0 up to size minus 1, where the size is an 8-bit page count (0 means no area). While the secure enable is clear, these pages behave like ordinary flash.
- R8: With the secure enable set, a write to a main-flash page inside the secure area sets the write-protect error, and a read of such a page sets the read error. In both cases there is no grant.
- R9: The secure-enable strobe sets the enable. Nothing except reset clears it.
- R10: A secure-size write takes effect only while the read-protection level is 0. At any other level it is ignored.
- R11: Each error flag stays set until its clear strobe. If a new error of the same kind arrives in the same cycle as the clear, the flag stays set.
- R12: The grant and error outputs update on the clock edge that accepts the request, so they are seen one cycle after it. Reset leaves all three outputs low. There is no grant without a valid request, and a refused request never grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_wr_i | input | 1 | 1 = program or erase, 0 = read |
| req_area_i | input | 2 | Target region: 0 main, 1 one-time-programmable, 2/3 system |
| req_page_i | input | 8 | Target page in main flash |
| zone_start_i | input | 16 | Staged start pages, zone 0 in bits 7:0, zone 1 in bits 15:8 |
| zone_end_i | input | 16 | Staged end pages, same packing |
| opt_reload_i | input | 1 | Load staged zone bounds |
| sec_size_wr_i | input | 1 | Write the secure-area size |
| sec_size_i | input | 8 | New secure-area size in pages |
| sec_en_set_i | input | 1 | Set the secure enable (sticky) |
| rdp_lvl_i | input | 2 | Read-protection level |
| dbg_attached_i | input | 1 | Debugger attached |
| boot_ram_i | input | 1 | Executing from RAM or system memory |
| wp_err_clr_i | input | 1 | Clear write-protect error |
| rd_err_clr_i | input | 1 | Clear read error |
| grant_o | output | 1 | One-cycle grant for an allowed request |
| wp_err_o | output | 1 | Sticky write-protect error |
| rd_err_o | output | 1 | Sticky read error |

## Verification
Two things can happen in the same cycle: software clears an error flag, and a new refused request of the same kind arrives. The bench provokes this by raising the clear strobe together with a write to a protected page, and also together with a secure-area read. It expects the flag to stay set, and then to drop after a clear that comes alone. A second overlap, an option reload arriving together with a request, is also driven, and the request must be judged against the old zone bounds. The constrained random phase mixes clear strobes, reloads, size writes and refused requests freely, so both overlaps recur many times against the bench's own model.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        AREA_MAIN = 2'd0,
        AREA_OTP  = 2'd1,
        AREA_SYS  = 2'd2,
        AREA_RSVD = 2'd3
    } area_e;

    typedef struct packed {
        logic grant;
        logic wp_err;
        logic rd_err;
    } verdict_t;

endpackage

// File: rtl/flash_zone_match.sv
module flash_zone_match #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] end_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              hit_o
);

    typedef struct packed {
        logic [PAGE_W-1:0] first;
        logic [PAGE_W-1:0] last;
    } zone_t;

    zone_t zone_d, zone_q;

    always_comb begin
        zone_d = zone_q;
        if (reload_i) begin
            zone_d.first = start_i;
            zone_d.last  = end_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zone_q.first <= '1;
            zone_q.last  <= '0;
        end else begin
            zone_q <= zone_d;
        end
    end

    always_comb begin
        if (zone_q.first == zone_q.last)
            hit_o = (page_i == zone_q.first);
        else if (zone_q.first < zone_q.last)
            hit_o = (page_i >= zone_q.first) && (page_i <= zone_q.last);
        else
            hit_o = 1'b0;
    end

    // R6
    zone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_i |=> $stable(zone_q));

endmodule

// File: rtl/flash_sec_area.sv
module flash_sec_area #(
    parameter int PAGE_W = 8,
    parameter int SEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_i,
    input  logic              size_wr_i,
    input  logic [SEC_W-1:0]  size_i,
    input  logic              rdp_zero_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              in_area_o,
    output logic              en_o
);

    localparam int CMP_W = (PAGE_W > SEC_W) ? PAGE_W : SEC_W;

    typedef struct packed {
        logic             en;
        logic [SEC_W-1:0] size;
    } sec_t;

    sec_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (en_set_i)
            sec_d.en = 1'b1;
        if (size_wr_i && rdp_zero_i)
            sec_d.size = size_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    logic [CMP_W-1:0] page_x, size_x;
    assign page_x    = CMP_W'(page_i);
    assign size_x    = CMP_W'(sec_q.size);
    assign in_area_o = page_x < size_x;
    assign en_o      = sec_q.en;

    // R9
    sec_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q.en |=> sec_q.en);

    // R10
    sec_size_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdp_zero_i |=> $stable(sec_q.size));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int SEC_W     = 8,
    parameter int NUM_ZONES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic                          req_wr_i,
    input  logic [1:0]                    req_area_i,
    input  logic [PAGE_W-1:0]             req_page_i,
    input  logic [NUM_ZONES*PAGE_W-1:0]   zone_start_i,
    input  logic [NUM_ZONES*PAGE_W-1:0]   zone_end_i,
    input  logic                          opt_reload_i,
    input  logic                          sec_size_wr_i,
    input  logic [SEC_W-1:0]              sec_size_i,
    input  logic                          sec_en_set_i,
    input  logic [1:0]                    rdp_lvl_i,
    input  logic                          dbg_attached_i,
    input  logic                          boot_ram_i,
    input  logic                          wp_err_clr_i,
    input  logic                          rd_err_clr_i,
    output logic                          grant_o,
    output logic                          wp_err_o,
    output logic                          rd_err_o
);

    logic [NUM_ZONES-1:0] zone_hit;

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        flash_zone_match #(.PAGE_W(PAGE_W)) u_zone (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload_i (opt_reload_i),
            .start_i  (zone_start_i[z*PAGE_W +: PAGE_W]),
            .end_i    (zone_end_i[z*PAGE_W +: PAGE_W]),
            .page_i   (req_page_i),
            .hit_o    (zone_hit[z])
        );
    end

    logic rdp_zero, sec_in_area, sec_en;
    assign rdp_zero = (rdp_lvl_i == 2'd0);

    flash_sec_area #(.PAGE_W(PAGE_W), .SEC_W(SEC_W)) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set_i   (sec_en_set_i),
        .size_wr_i  (sec_size_wr_i),
        .size_i     (sec_size_i),
        .rdp_zero_i (rdp_zero),
        .page_i     (req_page_i),
        .in_area_o  (sec_in_area),
        .en_o       (sec_en)
    );

    area_e area;
    logic  is_main, sec_hit, rdp_block, wr_deny, rd_deny;
    assign area      = area_e'(req_area_i);
    assign is_main   = (area == AREA_MAIN);
    assign sec_hit   = is_main && sec_en && sec_in_area;
    assign rdp_block = !rdp_zero && (dbg_attached_i || boot_ram_i);
    assign wr_deny   = req_wr_i && (!is_main || (|zone_hit) || sec_hit || rdp_block);
    assign rd_deny   = !req_wr_i && sec_hit;

    verdict_t vd_d, vd_q;

    always_comb begin
        vd_d.grant  = req_valid_i && !wr_deny && !rd_deny;
        vd_d.wp_err = (vd_q.wp_err && !wp_err_clr_i) || (req_valid_i && wr_deny);
        vd_d.rd_err = (vd_q.rd_err && !rd_err_clr_i) || (req_valid_i && rd_deny);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign grant_o  = vd_q.grant;
    assign wp_err_o = vd_q.wp_err;
    assign rd_err_o = vd_q.rd_err;

    // R4
    region_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_wr_i && (req_area_i != 2'd0) |=> wp_err_o && !grant_o);

    // R4
    region_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !req_wr_i && (req_area_i != 2'd0) |=> grant_o);

    // R5
    rdp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_wr_i && (rdp_lvl_i != 2'd0) && (dbg_attached_i || boot_ram_i)
        |=> wp_err_o && !grant_o);

    // R11
    wp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_err_o && !wp_err_clr_i |=> wp_err_o);

    // R11
    rd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o && !rd_err_clr_i |=> rd_err_o);

    // R12
    no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !grant_o);

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_wr = 0;
    logic [1:0]  req_area = 0;
    logic [7:0]  req_page = 0;
    logic [15:0] zs = '0, ze = '0;
    logic        reload = 0, size_wr = 0, en_set = 0;
    logic [7:0]  size_in = 0;
    logic [1:0]  rdp = 0;
    logic        dbg = 0, boot = 0, clr_wp = 0, clr_rd = 0;
    logic        grant, wp_err, rd_err;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_wr_i(req_wr), .req_area_i(req_area),
        .req_page_i(req_page), .zone_start_i(zs), .zone_end_i(ze),
        .opt_reload_i(reload), .sec_size_wr_i(size_wr), .sec_size_i(size_in),
        .sec_en_set_i(en_set), .rdp_lvl_i(rdp), .dbg_attached_i(dbg),
        .boot_ram_i(boot), .wp_err_clr_i(clr_wp), .rd_err_clr_i(clr_rd),
        .grant_o(grant), .wp_err_o(wp_err), .rd_err_o(rd_err)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model of the protection state
    logic [7:0] m_zs [2], m_ze [2];
    logic       m_en = 0;
    logic [7:0] m_size = 0;
    logic       m_wp = 0, m_rd = 0;

    function automatic logic covers(input logic [7:0] s, input logic [7:0] e, input logic [7:0] p);
        if (s == e) return p == s;
        if (s < e)  return (p >= s) && (p <= e);
        return 1'b0;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; reload = 0; size_wr = 0; en_set = 0; clr_wp = 0; clr_rd = 0;
    endtask

    // called at a negedge with inputs set; checks the outputs one edge later
    task automatic step(input string tag);
        logic sec_hit, wd, rdn, e_g, e_wp, e_rd;
        sec_hit = (req_area == 2'd0) && m_en && (req_page < m_size);
        wd  = req_wr && ((req_area != 2'd0) || covers(m_zs[0], m_ze[0], req_page) ||
              covers(m_zs[1], m_ze[1], req_page) || sec_hit ||
              ((rdp != 2'd0) && (dbg || boot)));
        rdn = !req_wr && sec_hit;
        e_g  = req_valid && !wd && !rdn;
        e_wp = (m_wp && !clr_wp) || (req_valid && wd);
        e_rd = (m_rd && !clr_rd) || (req_valid && rdn);
        if (reload) begin
            m_zs[0] = zs[7:0]; m_zs[1] = zs[15:8];
            m_ze[0] = ze[7:0]; m_ze[1] = ze[15:8];
        end
        if (en_set) m_en = 1'b1;
        if (size_wr && rdp == 2'd0) m_size = size_in;
        m_wp = e_wp; m_rd = e_rd;
        @(posedge clk);
        @(negedge clk);
        check(tag, "grant", grant, e_g);
        check(tag, "wp_err", wp_err, e_wp);
        check(tag, "rd_err", rd_err, e_rd);
        idle();
    endtask

    task automatic req(input logic wr, input logic [1:0] area, input logic [7:0] page);
        req_valid = 1; req_wr = wr; req_area = area; req_page = page;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_zs[0] = 8'hFF; m_zs[1] = 8'hFF; m_ze[0] = 8'h00; m_ze[1] = 8'h00;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12", "grant at reset", grant, 1'b0);
        check("R12", "wp_err at reset", wp_err, 1'b0);
        check("R12", "rd_err at reset", rd_err, 1'b0);

        // R2 reset zones protect nothing
        req(1, 0, 8'd255); step("R2");
        req(1, 0, 8'd0);   step("R2");
        // R6 staged but not reloaded
        zs = {8'd25, 8'd10}; ze = {8'd20, 8'd10};
        zs[15:8] = 8'd20; ze[15:8] = 8'd25;
        req(1, 0, 8'd10); step("R6");
        // R6 reload with a same-cycle request judged by old bounds
        reload = 1; req(1, 0, 8'd10); step("R6");
        // R1 single page
        req(1, 0, 8'd10); step("R1");
        clr_wp = 1; req(1, 0, 8'd11); step("R1");
        req(1, 0, 8'd9);  step("R1");
        // R3 range inclusive, reads unaffected
        req(1, 0, 8'd20); step("R3");
        req(1, 0, 8'd25); step("R3");
        clr_wp = 1; req(1, 0, 8'd26); step("R3");
        req(1, 0, 8'd19); step("R3");
        req(0, 0, 8'd22); step("R3");
        // R2 start above end
        zs[15:8] = 8'd40; ze[15:8] = 8'd30; reload = 1; step("R2");
        req(1, 0, 8'd35); step("R2");
        req(1, 0, 8'd40); step("R2");
        // R11 clear together with a new error keeps the flag
        req(1, 0, 8'd10); step("R11");
        clr_wp = 1; req(1, 0, 8'd10); step("R11");
        clr_wp = 1; step("R11");
        // R4 non-main regions
        for (int a = 1; a < 4; a++) begin
            req(1, a[1:0], 8'd100); step("R4");
            req(0, a[1:0], 8'd100); step("R4");
        end
        clr_wp = 1; step("R4");
        // R5 read-protection gating
        rdp = 1; dbg = 1; req(1, 0, 8'd100); step("R5");
        dbg = 0; boot = 1; req(1, 0, 8'd100); step("R5");
        boot = 0; clr_wp = 1; req(1, 0, 8'd100); step("R5");
        dbg = 1; req(0, 0, 8'd100); step("R5");
        rdp = 0; req(1, 0, 8'd100); step("R5");
        rdp = 2; boot = 1; dbg = 0; req(1, 0, 8'd101); step("R5");
        rdp = 0; boot = 0; clr_wp = 1; step("R5");
        // R7 secure area not yet enabled
        size_wr = 1; size_in = 8'd16; step("R7");
        req(1, 0, 8'd3); step("R7");
        req(0, 0, 8'd15); step("R7");
        // R10 size write ignored at nonzero level
        rdp = 1; size_wr = 1; size_in = 8'd4; step("R10");
        rdp = 0;
        // R8 enable, read and write in area
        en_set = 1; req(0, 0, 8'd15); step("R8");
        req(0, 0, 8'd15); step("R8");
        req(0, 0, 8'd16); step("R8");
        req(1, 0, 8'd3);  step("R8");
        req(0, 2'd1, 8'd3); step("R8");
        clr_rd = 1; req(0, 0, 8'd10); step("R11");
        clr_rd = 1; clr_wp = 1; step("R11");
        // R10 size still 16 after the ignored write
        req(0, 0, 8'd10); step("R10");
        clr_rd = 1; step("R10");
        // R9 enable stays set over idle cycles
        repeat (20) step("R9");
        req(0, 0, 8'd0); step("R9");
        clr_rd = 1; step("R9");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 3) != 0);
            req_wr    = $urandom_range(0, 1);
            req_area  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            req_page  = 8'($urandom_range(0, 63));
            reload    = ($urandom_range(0, 15) == 0);
            zs        = {8'($urandom_range(0, 63)), 8'($urandom_range(0, 63))};
            ze        = {8'($urandom_range(0, 63)), 8'($urandom_range(0, 63))};
            size_wr   = ($urandom_range(0, 15) == 0);
            size_in   = 8'($urandom_range(0, 40));
            rdp       = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            dbg       = ($urandom_range(0, 3) == 0);
            boot      = ($urandom_range(0, 5) == 0);
            clr_wp    = ($urandom_range(0, 3) == 0);
            clr_rd    = ($urandom_range(0, 3) == 0);
            step("R12");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule